// File: doc/BRIEF.md
# Secure Repeater Transmit Data Selector

This block chooses, bit by bit, what each outgoing port of a multi-port repeater transmits while a frame is being repeated, and what goes onto the shared inter-chip data bus. The received frame arrives as a serial NRZ bit stream qualified by an enable. Each port can send one of four sources: preamble from an on-chip alternating generator, the received bits themselves, a pseudo-random scrambling sequence, or a jam pattern. The choice follows the frame phase, the address-check strobes from an external lookup, collision reports and elasticity-buffer fault reports.

A destination-address mismatch affects only the port it names, and only if that port runs in secure mode. The bus keeps carrying the true data so that other cascaded units can run their own lookups. A qualified source-address mismatch scrambles every port and the bus. A collision or buffer fault overrides everything with jam. All of these choices hold until the receive enable drops, which returns the block to idle.

The stream has no back-pressure. A repeater cannot stall the wire, so there is no ready signal. Every enabled input bit produces exactly one output bit on each port and on the bus, one clock later.

Top module: `srtx_selector`

## Requirements
- R1: While `rx_en` is low on a clock edge, after that edge `tx_en`, `bus_en`, every `tx_data` bit and `bus_data` are 0. Reset leaves the same values. A low `rx_en` clears every latched cause, the delimiter search and the frame phase.
- R2: Before the start-of-frame delimiter completes, each port sends the generator bit, not the received bit. The generator outputs 1 on the first enabled bit of a frame and inverts on every later enabled bit.
- R3: The delimiter is the 8-bit serial sequence 1,0,1,0,1,0,1,1, with the oldest bit first. On the bit that completes it, the ports forward that received bit. The data phase then begins with the next bit and lasts until `rx_en` drops.
- R4: In the data phase, with no latched cause for a port, that port sends the received bit, delayed by one clock.
- R5: A `dst_miss[p]` strobe on an enabled bit latches a mismatch for port p only if `secure_en[p]` is 1. Otherwise it is ignored. From the following data-phase bit onward, port p sends the pseudo-random bit, and the other ports are unaffected.
- R6: A destination mismatch never changes `bus_data`. In the data phase the bus carries the received bit unless a source mismatch or jam is latched. Before the delimiter, the bus forwards the received bits.
- R7: A `src_miss` strobe on an enabled bit latches only while `src_chk_en` is 1. From the following data-phase bit onward, all ports and the bus send the pseudo-random bit.
- R8: The pseudo-random bit is the most significant bit of a 15-bit shift register with feedback from bits 15 and 14 (XOR), shifted toward the MSB. The register reloads a non-zero seed (default 0x1D3B) while `rx_en` is low and advances once per enabled bit, so the first bit of a frame uses the seed's MSB.
- R9: A `coll` or `fifo_err` on an enabled bit latches jam. From the following bit, in any phase, all ports and the bus send the generator bit, which overrides scrambling.
- R10: Latched causes persist until `rx_en` drops. The frame after a jammed or scrambled frame starts clean, with preamble and then real data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Received bit valid, frame in progress |
| rx_data | input | 1 | Received NRZ bit |
| secure_en | input | NUM_PORTS | Per-port secure mode |
| dst_miss | input | NUM_PORTS | Per-port destination mismatch strobe |
| src_chk_en | input | 1 | Qualifies source mismatch strobes |
| src_miss | input | 1 | Source mismatch strobe |
| coll | input | 1 | Collision report |
| fifo_err | input | 1 | Elasticity-buffer error or overflow |
| tx_en | output | 1 | Ports transmitting |
| tx_data | output | NUM_PORTS | Per-port transmit bit |
| bus_en | output | 1 | Bus data valid |
| bus_data | output | 1 | Inter-chip bus data bit |

## Verification
Each output bit is due one clock edge after the input bit it answers. A cause strobe changes outputs starting with the bit after the one presented with it, so its first visible effect comes two edges after the strobe. The bench drives inputs on the falling edge and advances its own model at the rising edge, using the pre-edge state. It compares on the next falling edge, which keeps every comparison aligned to that one-edge latency and the strobe-to-effect delay.

// File: rtl/srtx_pkg.sv
package srtx_pkg;
  typedef enum logic [2:0] {
    SRC_IDLE  = 3'd0,
    SRC_PRE   = 3'd1,
    SRC_REAL  = 3'd2,
    SRC_SCRAM = 3'd3,
    SRC_JAM   = 3'd4
  } src_sel_e;

  // Priority: idle, then jam, then scramble (data phase only), then real data
  function automatic src_sel_e pick_src(input logic active, input logic jam,
                                        input logic scram, input logic data_ph,
                                        input logic pass_now);
    if (!active)               return SRC_IDLE;
    else if (jam)              return SRC_JAM;
    else if (data_ph && scram) return SRC_SCRAM;
    else if (data_ph || pass_now) return SRC_REAL;
    else                       return SRC_PRE;
  endfunction

  function automatic logic drive_bit(input src_sel_e sel, input logic rx_bit,
                                     input logic gen_bit, input logic prbs_bit);
    case (sel)
      SRC_PRE, SRC_JAM: return gen_bit;
      SRC_REAL:         return rx_bit;
      SRC_SCRAM:        return prbs_bit;
      default:          return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/srtx_pattern_gen.sv
module srtx_pattern_gen #(
  parameter int LFSR_W = 15,
  parameter int TAP_A  = 15,
  parameter int TAP_B  = 14,
  parameter logic [LFSR_W-1:0] SEED = 15'h1D3B
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic gen_bit,
  output logic prbs_bit
);
  logic              alt_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic              fb;

  assign fb       = lfsr_q[TAP_A-1] ^ lfsr_q[TAP_B-1];
  assign gen_bit  = alt_q;
  assign prbs_bit = lfsr_q[LFSR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q  <= 1'b1;
      lfsr_q <= SEED;
    end else if (!active) begin
      alt_q  <= 1'b1;
      lfsr_q <= SEED;
    end else begin
      alt_q  <= ~alt_q;
      lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
    end
  end

  p_alt_toggles_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (!active || gen_bit != $past(gen_bit)));
  p_prbs_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/srtx_sfd_det.sv
module srtx_sfd_det #(
  parameter int SFD_W = 8,
  parameter logic [SFD_W-1:0] SFD_PAT = 8'hAB
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rx_bit,
  output logic sfd_hit,
  output logic data_ph
);
  logic [SFD_W-2:0] hist_q;

  assign sfd_hit = active && !data_ph && ({hist_q, rx_bit} == SFD_PAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      data_ph <= 1'b0;
    end else if (!active) begin
      hist_q  <= '0;
      data_ph <= 1'b0;
    end else begin
      hist_q  <= {hist_q[SFD_W-3:0], rx_bit};
      if (sfd_hit) data_ph <= 1'b1;
    end
  end

  p_phase_after_sfd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sfd_hit |=> data_ph);
  p_phase_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !data_ph);
endmodule

// File: rtl/srtx_cause_latch.sv
module srtx_cause_latch #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic [NUM_PORTS-1:0] secure_en,
  input  logic [NUM_PORTS-1:0] dst_miss,
  input  logic                 src_chk_en,
  input  logic                 src_miss,
  input  logic                 coll,
  input  logic                 fifo_err,
  output logic [NUM_PORTS-1:0] dst_f,
  output logic                 src_f,
  output logic                 jam_f
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_f <= '0;
      src_f <= 1'b0;
      jam_f <= 1'b0;
    end else if (!active) begin
      dst_f <= '0;
      src_f <= 1'b0;
      jam_f <= 1'b0;
    end else begin
      dst_f <= dst_f | (dst_miss & secure_en);
      src_f <= src_f | (src_miss & src_chk_en);
      jam_f <= jam_f | coll | fifo_err;
    end
  end

  p_jam_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active && (coll || fifo_err) |=> jam_f);
  p_src_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active && !src_f && !src_chk_en |=> !src_f);
  p_flags_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!jam_f && !src_f && dst_f == '0));
endmodule

// File: rtl/srtx_selector.sv
module srtx_selector
  import srtx_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int LFSR_W    = 15,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 15'h1D3B
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en,
  input  logic                 rx_data,
  input  logic [NUM_PORTS-1:0] secure_en,
  input  logic [NUM_PORTS-1:0] dst_miss,
  input  logic                 src_chk_en,
  input  logic                 src_miss,
  input  logic                 coll,
  input  logic                 fifo_err,
  output logic                 tx_en,
  output logic [NUM_PORTS-1:0] tx_data,
  output logic                 bus_en,
  output logic                 bus_data
);
  logic                 gen_bit, prbs_bit, sfd_hit, data_ph, src_f, jam_f;
  logic [NUM_PORTS-1:0] dst_f;
  logic [NUM_PORTS-1:0] port_nxt;
  src_sel_e             bus_sel;

  srtx_pattern_gen #(.LFSR_W(LFSR_W), .TAP_A(LFSR_W), .TAP_B(LFSR_W-1),
                     .SEED(LFSR_SEED)) u_gen (
    .clk(clk), .rst_n(rst_n), .active(rx_en),
    .gen_bit(gen_bit), .prbs_bit(prbs_bit));

  srtx_sfd_det u_sfd (
    .clk(clk), .rst_n(rst_n), .active(rx_en), .rx_bit(rx_data),
    .sfd_hit(sfd_hit), .data_ph(data_ph));

  srtx_cause_latch #(.NUM_PORTS(NUM_PORTS)) u_cause (
    .clk(clk), .rst_n(rst_n), .active(rx_en),
    .secure_en(secure_en), .dst_miss(dst_miss),
    .src_chk_en(src_chk_en), .src_miss(src_miss),
    .coll(coll), .fifo_err(fifo_err),
    .dst_f(dst_f), .src_f(src_f), .jam_f(jam_f));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    src_sel_e sel;
    assign sel = pick_src(rx_en, jam_f, dst_f[p] | src_f, data_ph, sfd_hit);
    assign port_nxt[p] = drive_bit(sel, rx_data, gen_bit, prbs_bit);
  end

  // Bus forwards received bits even before the delimiter; only source
  // mismatch or jam alters it.
  assign bus_sel = pick_src(rx_en, jam_f, src_f, data_ph, 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en    <= 1'b0;
      tx_data  <= '0;
      bus_en   <= 1'b0;
      bus_data <= 1'b0;
    end else begin
      tx_en    <= rx_en;
      tx_data  <= port_nxt;
      bus_en   <= rx_en;
      bus_data <= drive_bit(bus_sel, rx_data, gen_bit, prbs_bit);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!tx_en && tx_data == '0 && !bus_en && !bus_data));
  p_real_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && data_ph && !jam_f && !src_f && !dst_f[0] |=> tx_data[0] == $past(rx_data));
  p_bus_keeps_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && data_ph && !jam_f && !src_f |=> bus_data == $past(rx_data));
  p_src_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && data_ph && src_f && !jam_f |=> tx_data == {NUM_PORTS{bus_data}});
  p_jam_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && jam_f |=> tx_data == {NUM_PORTS{bus_data}});
endmodule

// File: tb/srtx_selector_bench.sv
module srtx_selector_bench;
  localparam int NP = 4;
  localparam logic [14:0] SEED = 15'h1D3B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, rx_data = 1'b0, src_chk_en = 1'b0, src_miss = 1'b0;
  logic coll = 1'b0, fifo_err = 1'b0;
  logic [NP-1:0] secure_en = '0, dst_miss = '0;
  logic tx_en, bus_en, bus_data;
  logic [NP-1:0] tx_data;

  int n_tests = 0, n_fail = 0;
  string ctx_tag = "";

  // bench model state
  logic [6:0] m_sh; logic m_dph, m_sf, m_jf, m_gen; logic [NP-1:0] m_df; logic [14:0] m_lfsr;

  always #4 clk = ~clk;

  srtx_selector #(.NUM_PORTS(NP)) u_srtx_selector (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_data(rx_data),
    .secure_en(secure_en), .dst_miss(dst_miss), .src_chk_en(src_chk_en),
    .src_miss(src_miss), .coll(coll), .fifo_err(fifo_err),
    .tx_en(tx_en), .tx_data(tx_data), .bus_en(bus_en), .bus_data(bus_data));

  task automatic model_reset();
    m_sh = '0; m_dph = 0; m_sf = 0; m_jf = 0; m_gen = 1; m_df = '0; m_lfsr = SEED;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic d, input logic [NP-1:0] dm,
                      input logic sm, input logic cl, input logic fe);
    logic [NP-1:0] e_tx; string t_tx [NP]; logic e_bus; string t_bus; logic hit;
    rx_en = en; rx_data = d; dst_miss = dm; src_miss = sm; coll = cl; fifo_err = fe;
    @(posedge clk);
    hit = en && !m_dph && ({m_sh, d} == 8'hAB);
    for (int p = 0; p < NP; p++) begin
      if (!en)                             begin e_tx[p] = 0;          t_tx[p] = "R1"; end
      else if (m_jf)                       begin e_tx[p] = m_gen;      t_tx[p] = "R9"; end
      else if (m_dph && m_sf)              begin e_tx[p] = m_lfsr[14]; t_tx[p] = "R7 R8"; end
      else if (m_dph && m_df[p])           begin e_tx[p] = m_lfsr[14]; t_tx[p] = "R5 R8"; end
      else if (m_dph)                      begin e_tx[p] = d; t_tx[p] = (ctx_tag != "") ? ctx_tag : "R4"; end
      else if (hit)                        begin e_tx[p] = d;          t_tx[p] = "R3"; end
      else                                 begin e_tx[p] = m_gen; t_tx[p] = (ctx_tag != "") ? ctx_tag : "R2"; end
    end
    if (!en)                 begin e_bus = 0;          t_bus = "R1"; end
    else if (m_jf)           begin e_bus = m_gen;      t_bus = "R9"; end
    else if (m_dph && m_sf)  begin e_bus = m_lfsr[14]; t_bus = "R7 R8"; end
    else                     begin e_bus = d;          t_bus = "R6"; end
    if (!en) model_reset();
    else begin
      m_sh = {m_sh[5:0], d};
      m_dph = m_dph | hit;
      m_df = m_df | (dm & secure_en);
      m_sf = m_sf | (sm & src_chk_en);
      m_jf = m_jf | cl | fe;
      m_gen = ~m_gen;
      m_lfsr = {m_lfsr[13:0], m_lfsr[14] ^ m_lfsr[13]};
    end
    @(negedge clk);
    chk(tx_en, en, "R1", "tx_en");
    chk(bus_en, en, "R1", "bus_en");
    for (int p = 0; p < NP; p++) chk(tx_data[p], e_tx[p], t_tx[p], $sformatf("tx_data[%0d]", p));
    chk(bus_data, e_bus, t_bus, "bus_data");
  endtask

  // *_at = -1 means no strobe; index counts enabled bits from frame start
  task automatic frame(input int pre_len, input int data_len, input logic [NP-1:0] sec,
                       input logic sachk, input int da_at, input logic [NP-1:0] da_m,
                       input int sa_at, input int col_at, input int fe_at, input int gap);
    int total; logic d;
    secure_en = sec; src_chk_en = sachk;
    total = pre_len + 2 + data_len;
    for (int i = 0; i < total; i++) begin
      if (i < pre_len) d = ~i[0];
      else if (i < pre_len + 2) d = 1'b1;
      else d = 1'($urandom % 2);
      step(1'b1, d, (i == da_at) ? da_m : '0, i == sa_at, i == col_at, i == fe_at);
    end
    for (int g = 0; g < gap; g++) step(1'b0, 1'($urandom % 2), '0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    chk(tx_en, 1'b0, "R1", "reset tx_en");
    chk(bus_data, 1'b0, "R1", "reset bus_data");
    rst_n = 1'b1;
    @(negedge clk);
    // R4: plain frame, no security
    frame(8, 24, '0, 1'b0, -1, '0, -1, -1, -1, 2);
    // R5: port 1 secure, strobe also hits non-secure port 2 (ignored); bus kept (R6)
    frame(10, 30, 4'b0010, 1'b0, 16, 4'b0110, -1, -1, -1, 1);
    // R7: source mismatch ignored while checking disabled
    frame(6, 20, 4'b1111, 1'b0, -1, '0, 12, -1, -1, 1);
    // R7: source mismatch scrambles all ports and bus
    frame(6, 20, 4'b0000, 1'b1, -1, '0, 12, -1, -1, 1);
    // R9: collision during preamble
    frame(12, 10, '0, 1'b0, -1, '0, -1, 3, -1, 1);
    // R9: buffer fault overrides existing scrambling
    frame(8, 30, 4'b1111, 1'b1, 12, 4'b1111, 14, -1, 20, 1);
    // R10: next frame after causes starts clean
    ctx_tag = "R10";
    frame(8, 16, 4'b1111, 1'b1, -1, '0, -1, -1, -1, 2);
    ctx_tag = "";
    for (int f = 0; f < 150; f++) begin
      int pl, dl, da, sa, co, fe;
      pl = 6 + 2 * int'($urandom % 8);
      dl = int'($urandom % 40);
      da = ($urandom % 2 == 1) ? int'($urandom % (pl + dl + 2)) : -1;
      sa = ($urandom % 4 == 0) ? int'($urandom % (pl + dl + 2)) : -1;
      co = ($urandom % 5 == 0) ? int'($urandom % (pl + dl + 2)) : -1;
      fe = ($urandom % 8 == 0) ? int'($urandom % (pl + dl + 2)) : -1;
      frame(pl, dl, NP'($urandom), 1'($urandom % 2), da, NP'($urandom), sa, co, fe,
            1 + int'($urandom % 3));
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule